// File: doc/BRIEF.md
# Pin Change Event Queue

This block turns a vector of pending pin-change flags into an ordered stream of pin numbers. A producer presents a 32-bit pending vector together with a 32-bit enable mask. The block keeps only the bits that are set in both, walks them one bit position per clock from bit 0 upward, and writes the position of every set bit into a 64-entry queue of bytes.

A consumer reads the oldest entry from a show-ahead data port and removes it with a one-cycle pop strobe. A non-empty flag supports polling, and a level interrupt stays high as long as any entry is stored. If the queue fills during a walk, the bit that found it full and every later bit of that vector are discarded. A sticky overflow flag records the loss until the consumer clears it.

Top module: `pinchg_evq`

## Requirements
- R1: Only bit positions that are set in both `vec_pend` and `vec_mask` produce entries. A vector whose masked value is zero produces none and leaves `vec_ready` high.
- R2: Each entry is an 8-bit value equal to the bit position (0 to 31). The positions of one vector are stored in ascending order.
- R3: The queue holds at most 64 entries. The number of stored entries never exceeds 64.
- R4: When a set bit meets a full queue (64 entries), that bit and every remaining set bit of the same vector are dropped. The walk ends, and `vec_ready` is high on the next cycle.
- R5: `rd_data` always shows the oldest stored entry. Each pop removes exactly that entry, so partial reads keep the remaining entries in arrival order.
- R6: `rd_nonempty` and `irq` are both high exactly while at least one entry is stored.
- R7: The walk examines one bit position per clock. After a vector whose highest masked bit is position k is accepted, `vec_ready` stays low for k+1 cycles. A `vec_valid` seen while `vec_ready` is low is ignored.
- R8: A push and a pop in the same cycle leave the number of stored entries unchanged.
- R9: Synchronous active-low reset empties the queue, aborts any walk in progress (`vec_ready` high) and clears the overflow flag.
- R10: `ovf_flag` goes high on the cycle after any entry is dropped. It stays high until `ovf_clr` is asserted, which clears it on the next edge.
- R11: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_valid | input | 1 | Offer a new pending vector |
| vec_pend | input | 32 | Pending change flags, one per pin |
| vec_mask | input | 32 | Enable mask, one per pin |
| vec_ready | output | 1 | High when idle and able to take a vector |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Oldest stored pin number |
| rd_nonempty | output | 1 | At least one entry stored |
| irq | output | 1 | Level interrupt, high while entries are stored |
| ovf_flag | output | 1 | Sticky flag: an entry was dropped |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The assertions assume that `vec_valid`, `rd_pop` and `ovf_clr` are clean single-bit levels sampled at the rising edge. They assume the producer holds `vec_pend` and `vec_mask` only for the acceptance cycle, since the block latches the masked value. Stimulus changes all inputs on the falling edge only. The bench offers vectors while `vec_ready` is high, except in the one test that deliberately offers a vector during a walk. It fills the queue to exactly 64 entries before provoking a drop, so the capacity and ordering properties are exercised at their limit.

// File: rtl/pinchg_pkg.sv
// Package pinchg_pkg
// Shared widths and types for the pin change event queue.
// Assumes an entry is one byte, wide enough for any pin number in use.
package pinchg_pkg;
    localparam int IDX_W = 8;
    typedef logic [IDX_W-1:0] pin_idx_t;
endpackage

// File: rtl/pinchg_scan.sv
// Module pinchg_scan
// Latches pend & mask when idle and walks it one bit per clock, lowest bit
// first. Each set bit becomes a push request carrying its position. If a set
// bit meets a full queue, the walk is abandoned and a drop pulse is raised.
// Assumes VEC_W >= 2 and that q_full reflects the queue state this cycle.
module pinchg_scan
    import pinchg_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_pend,
    input  logic [VEC_W-1:0] vec_mask,
    input  logic             q_full,
    output logic             vec_ready,
    output logic             push_en,
    output pin_idx_t         push_idx,
    output logic             drop
);
    localparam int SEL_W = $clog2(VEC_W);

    logic             busy;
    logic [VEC_W-1:0] work;
    logic [VEC_W-1:0] work_nxt;
    logic [SEL_W-1:0] pos;
    logic             cur_bit;
    logic [VEC_W-1:0] masked_in;

    // Purpose: decode the bit under the cursor into push or drop.
    always_comb begin
        masked_in = vec_pend & vec_mask;
        cur_bit   = busy && work[pos];
        push_en   = cur_bit && !q_full;
        drop      = cur_bit && q_full;
        push_idx  = pin_idx_t'(pos);
        work_nxt  = work;
        work_nxt[pos] = 1'b0;
        vec_ready = !busy;
    end

    // Purpose: accept a vector when idle, then advance the cursor each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            work <= '0;
            pos  <= '0;
        end else if (!busy) begin
            if (vec_valid && (masked_in != '0)) begin
                busy <= 1'b1;
                work <= masked_in;
                pos  <= '0;
            end
        end else if (drop) begin
            busy <= 1'b0;
            work <= '0;
            pos  <= '0;
        end else begin
            work <= work_nxt;
            pos  <= pos + 1'b1;
            if (work_nxt == '0) begin
                busy <= 1'b0;
            end
        end
    end

    // R7: accepting a non-empty vector takes the walker out of the idle state
    p_accept_goes_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready && (masked_in != '0)) |=> !vec_ready);

    // R4: a drop ends the walk at once
    p_drop_ends_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> vec_ready);

    // R1: an empty masked vector never starts a walk
    p_empty_vec_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ready && (masked_in == '0)) |=> vec_ready);
endmodule

// File: rtl/pinchg_fifo.sv
// Module pinchg_fifo
// Show-ahead circular queue of bytes. A push while full and a pop while
// empty are ignored. Assumes DEPTH >= 2.
module pinchg_fifo
    import pinchg_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  pin_idx_t wdata,
    input  logic     pop,
    output pin_idx_t rdata,
    output logic     full,
    output logic     empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    pin_idx_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Purpose: status flags and qualified strobes.
    always_comb begin
        full    = (count == CAP);
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = mem[rd_ptr];
    end

    // Purpose: store pushed bytes.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Purpose: move the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy stays within capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

    // R8: simultaneous push and pop hold the level
    p_pushpop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop) |=> $stable(count));

    // R11: a pop on an empty queue with no push leaves it empty
    p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/pinchg_evq.sv
// Module pinchg_evq
// Top of the pin change event queue: a bit walker feeding a byte queue,
// with a level interrupt and a sticky overflow flag. Assumes inputs are
// synchronous to clk.
module pinchg_evq
    import pinchg_pkg::*;
#(
    parameter int VEC_W = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_pend,
    input  logic [VEC_W-1:0] vec_mask,
    output logic             vec_ready,
    input  logic             rd_pop,
    output logic [IDX_W-1:0] rd_data,
    output logic             rd_nonempty,
    output logic             irq,
    output logic             ovf_flag,
    input  logic             ovf_clr
);
    logic     q_full;
    logic     q_empty;
    logic     push_en;
    logic     drop;
    pin_idx_t push_idx;
    pin_idx_t head;

    pinchg_scan #(.VEC_W(VEC_W)) scan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_valid (vec_valid),
        .vec_pend  (vec_pend),
        .vec_mask  (vec_mask),
        .q_full    (q_full),
        .vec_ready (vec_ready),
        .push_en   (push_en),
        .push_idx  (push_idx),
        .drop      (drop)
    );

    pinchg_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_en),
        .wdata (push_idx),
        .pop   (rd_pop),
        .rdata (head),
        .full  (q_full),
        .empty (q_empty)
    );

    // Purpose: drive the reader-side outputs.
    always_comb begin
        rd_data     = head;
        rd_nonempty = !q_empty;
        irq         = !q_empty;
    end

    // Purpose: sticky overflow flag, set by a drop, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (drop) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    // R4: the walker never pushes into a full queue
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !q_full);

    // R6: a push always leaves the queue non-empty with the interrupt raised
    p_irq_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (rd_nonempty && irq));

    // R10: the flag holds until cleared
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R10: a drop raises the flag
    p_drop_sets_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_flag);
endmodule

// File: tb/pinchg_evq_tb_top.sv
module pinchg_evq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_valid = 1'b0;
    logic [31:0] vec_pend = '0;
    logic [31:0] vec_mask = '0;
    logic        vec_ready;
    logic        rd_pop = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_nonempty;
    logic        irq;
    logic        ovf_flag;
    logic        ovf_clr = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pinchg_evq dut_i (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_pend(vec_pend),
        .vec_mask(vec_mask), .vec_ready(vec_ready), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_nonempty(rd_nonempty), .irq(irq),
        .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
    );

    // Table of {pend, mask} stimulus; expected entries are derived from it.
    localparam logic [63:0] VECS [6] = '{
        {32'h0000_0001, 32'hFFFF_FFFF},
        {32'h8000_0001, 32'h8000_0000},
        {32'hA5A5_0F0F, 32'h0F0F_FFFF},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'h1234_5678, 32'hFFFF_FFFF},
        {32'h0000_0000, 32'hFFFF_FFFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] p, input logic [31:0] m);
        @(negedge clk);
        vec_valid = 1'b1; vec_pend = p; vec_mask = m;
        @(negedge clk);
        vec_valid = 1'b0;
        while (!vec_ready) @(negedge clk);
    endtask

    task automatic pop_one;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    // Drain and compare against the ascending set positions of v.
    task automatic drain_expect(input logic [31:0] v, input string req);
        for (int b = 0; b < 32; b++) begin
            if (v[b]) begin
                chk(rd_nonempty, req, rd_nonempty, 1);
                chk(rd_data == b[7:0], req, rd_data, b);
                pop_one();
            end
        end
        chk(!rd_nonempty && !irq, "R6", rd_nonempty, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(vec_ready, "R9", vec_ready, 1);
        chk(!rd_nonempty && !irq, "R6", rd_nonempty, 0);
        chk(!ovf_flag, "R9", ovf_flag, 0);

        // R1 R2 R5: table walk
        for (int i = 0; i < 6; i++) begin
            logic [31:0] mv;
            mv = VECS[i][63:32] & VECS[i][31:0];
            send(VECS[i][63:32], VECS[i][31:0]);
            chk(rd_nonempty == (mv != 0), "R1", rd_nonempty, mv != 0);
            chk(irq == (mv != 0), "R6", irq, mv != 0);
            drain_expect(mv, "R2");
        end

        // R7: highest bit 31 keeps ready low 32 cycles; a vector offered
        // meanwhile is ignored
        begin
            int lowc = 0;
            @(negedge clk);
            vec_valid = 1'b1; vec_pend = 32'h8000_0000; vec_mask = '1;
            @(negedge clk);
            vec_pend = 32'h0000_0020;
            while (!vec_ready) begin
                lowc++;
                if (lowc == 3) vec_valid = 1'b0;
                @(negedge clk);
            end
            vec_valid = 1'b0;
            chk(lowc == 32, "R7", lowc, 32);
            drain_expect(32'h8000_0000, "R7");
        end

        // R11: pop on empty has no effect
        pop_one();
        chk(!rd_nonempty, "R11", rd_nonempty, 0);
        send(32'h0000_0008, '1);
        chk(rd_data == 8'd3, "R11", rd_data, 3);
        pop_one();
        chk(!rd_nonempty, "R11", rd_nonempty, 0);

        // R8: pop coinciding with the first push keeps the level
        send(32'h0000_0080, '1);
        @(negedge clk);
        vec_valid = 1'b1; vec_pend = 32'h7; vec_mask = '1;
        @(negedge clk);
        vec_valid = 1'b0;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        while (!vec_ready) @(negedge clk);
        drain_expect(32'h7, "R8");

        // R3 R4 R10: fill to 64, then overflow
        send('1, '1);
        send('1, '1);
        chk(!ovf_flag, "R3", ovf_flag, 0);
        send(32'h5, '1);
        chk(ovf_flag, "R4", ovf_flag, 1);
        chk(vec_ready, "R4", vec_ready, 1);
        pop_one();
        send(32'hF, '1);
        repeat (2) @(negedge clk);
        chk(ovf_flag, "R10", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(!ovf_flag, "R10", ovf_flag, 0);
        // R5: expect 1..31, 0..31, 0 then empty (64 entries)
        for (int k = 1; k < 32; k++) begin
            chk(rd_data == k[7:0], "R5", rd_data, k);
            pop_one();
        end
        for (int k = 0; k < 32; k++) begin
            chk(rd_data == k[7:0], "R5", rd_data, k);
            pop_one();
        end
        chk(rd_nonempty && rd_data == 8'd0, "R3", rd_data, 0);
        pop_one();
        chk(!rd_nonempty, "R3", rd_nonempty, 0);

        // R9: reset mid-walk
        send(32'h1, '1);
        @(negedge clk);
        vec_valid = 1'b1; vec_pend = 32'h8000_0000; vec_mask = '1;
        @(negedge clk);
        vec_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vec_ready, "R9", vec_ready, 1);
        chk(!rd_nonempty && !irq, "R9", rd_nonempty, 0);
        repeat (40) @(negedge clk);
        chk(!rd_nonempty, "R9", rd_nonempty, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule